// File: doc/BRIEF.md
# CPU Clock-Enable and Reset Controller

This block derives the processor clock from a single master oscillator (nominally 28 MHz, the same one that drives video). It does this with a one-cycle clock-enable pulse at 14, 7 or 3.5 MHz, so every CPU rate stays phase-locked to the video timing. The rate comes from a two-bit software override code. When that code is zero, control falls back to a two-bit hardware selector. A new rate is taken up only when an enable pulse fires, so the CPU never sees a shortened cycle.

The block also sequences three kinds of reset. Power-on reset is asynchronous: it forces every reset output, selects the slowest rate and forces the local video oscillator. A full system request and a compatibility-only request both start a synchronous, fixed-length reset that leaves the clock enable running, so memory refresh is never starved. The compatibility request spares the extended configuration ports. The printer strobe output is held high while any reset is in force.

Top module: `cpu_clock_reset`

## Requirements
- R1: While `porN` is low, `cpuRstN`, `periphRstN`, `basePortRstN` and `extPortRstN` are 0, `forceLocalOsc` is 1 and `speedStatus` is 3'b001. All of these take effect without waiting for a clock edge. They are released on the second rising clock edge after `porN` returns high.
- R2: `cpuEn` is a single-cycle pulse. Pulses are spaced 4*FAST_DIV master cycles apart at 3.5 MHz, 2*FAST_DIV at 7 MHz and FAST_DIV at 14 MHz (8, 4 and 2 with defaults).
- R3: `forceCode` overrides `hwSel`: 2'b01 selects 3.5 MHz, 2'b10 selects 7 MHz and 2'b11 selects 14 MHz.
- R4: With `forceCode` = 2'b00, `hwSel` decides the rate: 2'b10 selects 7 MHz, 2'b11 selects 14 MHz, and 2'b00 or 2'b01 select 3.5 MHz.
- R5: A rate change is taken up only on the clock edge at which `cpuEn` is high. The interval that ends with the first pulse after the change keeps the old length, and every interval is a whole period of one rate.
- R6: `speedStatus` is one-hot and shows the rate in effect: bit 0 for 3.5 MHz, bit 1 for 7 MHz, bit 2 for 14 MHz (readback bits 5, 6 and 7). It changes on the edge that ends a `cpuEn` cycle.
- R7: A high `sysReq` sampled on a rising edge drives `cpuRstN`, `periphRstN`, `basePortRstN` and `extPortRstN` low from that edge for exactly RST_CYCLES master cycles (56 by default, 2 us at 28 MHz).
- R8: A high `compReq` drives `cpuRstN`, `periphRstN` and `basePortRstN` low for RST_CYCLES cycles, while `extPortRstN` stays high.
- R9: A request that arrives during a synchronous reset restarts the full count from its own edge. Once a system request has been seen, the extended ports stay in reset until that reset ends.
- R10: `cpuEn` keeps its period and phase throughout a synchronous reset.
- R11: `printerStrobe` is 1 during any reset (power-on or synchronous). Otherwise it follows `strobeIn`.
- R12: `sysReq` and `compReq` high on the same edge act as a system reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master oscillator clock |
| porN | input | 1 | Asynchronous power-on reset, active low |
| sysReq | input | 1 | Synchronous full system reset request |
| compReq | input | 1 | Synchronous compatibility reset request |
| hwSel | input | 2 | Hardware rate selector |
| forceCode | input | 2 | Software rate override code |
| strobeIn | input | 1 | Printer strobe value from its port register |
| cpuEn | output | 1 | CPU clock-enable pulse |
| speedStatus | output | 3 | One-hot rate in effect |
| cpuRstN | output | 1 | CPU reset, active low |
| periphRstN | output | 1 | Peripheral reset, active low |
| basePortRstN | output | 1 | Original-machine output port reset, active low |
| extPortRstN | output | 1 | Extended configuration port reset, active low |
| printerStrobe | output | 1 | Printer strobe, forced high in reset |
| forceLocalOsc | output | 1 | Forces the local video oscillator during power-on reset |

## Verification
Power-on reset outputs are checked one time step after `porN` falls, with no clock edge in between. Their release is checked at the second falling edge after `porN` rises. A synchronous request driven at one falling edge is registered on the next rising edge, so the reset outputs are low from the following falling edge onward. The bench counts the low samples and compares the count with RST_CYCLES, or with the restart offset plus RST_CYCLES. Enable spacing is measured in falling edges from one pulse to the next. Because a rate change is taken up only on the edge that ends a pulse cycle, the bench changes the rate one cycle after a pulse. It then expects the old spacing once, followed by the new spacing, with `speedStatus` still old on the pulse cycle itself.

// File: rtl/clkrst_pkg.sv
`timescale 1ns/1ps
package clkrst_pkg;

  typedef enum logic [2:0] {
    SPD_SLOW = 3'b001,
    SPD_MID  = 3'b010,
    SPD_FAST = 3'b100
  } speed_e;

  // strobes from the sequencing control into the datapath
  typedef struct packed {
    logic   rstLoad;
    logic   rstActive;
    logic   rstFull;
    speed_e reqSpeed;
  } ctrl_strobe_t;

  function automatic speed_e decodeSpeed(input logic [1:0] forceCode,
                                         input logic [1:0] hwSel);
    speed_e s;
    case (forceCode)
      2'b01:   s = SPD_SLOW;
      2'b10:   s = SPD_MID;
      2'b11:   s = SPD_FAST;
      default: begin
        case (hwSel)
          2'b10:   s = SPD_MID;
          2'b11:   s = SPD_FAST;
          default: s = SPD_SLOW;
        endcase
      end
    endcase
    return s;
  endfunction

endpackage

// File: rtl/clkrst_porsync.sv
`timescale 1ns/1ps
module clkrst_porsync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic porN,
  output logic porRst
);
  logic [STAGES-1:0] syncChain;

  always_ff @(posedge clk or negedge porN) begin
    if (!porN) syncChain <= '0;
    else       syncChain <= {syncChain[STAGES-2:0], 1'b1};
  end

  assign porRst = ~syncChain[STAGES-1];
endmodule

// File: rtl/clkrst_ctrl.sv
`timescale 1ns/1ps
module clkrst_ctrl
  import clkrst_pkg::*;
(
  input  logic         clk,
  input  logic         porRst,
  input  logic         sysReq,
  input  logic         compReq,
  input  logic [1:0]   hwSel,
  input  logic [1:0]   forceCode,
  input  logic         cntDone,
  output ctrl_strobe_t strobes
);
  logic rstActive;
  logic rstFull;
  logic anyReq;

  assign anyReq = sysReq | compReq;

  always_ff @(posedge clk or posedge porRst) begin
    if (porRst) begin
      rstActive <= 1'b0;
      rstFull   <= 1'b0;
    end else if (anyReq) begin
      rstActive <= 1'b1;
      rstFull   <= sysReq | (rstActive & rstFull);
    end else if (rstActive && cntDone) begin
      rstActive <= 1'b0;
      rstFull   <= 1'b0;
    end
  end

  always_comb begin
    strobes.rstLoad   = anyReq;
    strobes.rstActive = rstActive;
    strobes.rstFull   = rstFull;
    strobes.reqSpeed  = decodeSpeed(forceCode, hwSel);
  end

  // R7 / R12: a system request always yields a full reset next cycle
  p_sys_full_r7: assert property (@(posedge clk) disable iff (porRst)
    sysReq |=> (rstActive && rstFull));

  // R9: a full reset is not downgraded by a later compatibility request
  p_keep_full_r9: assert property (@(posedge clk) disable iff (porRst)
    (rstActive && rstFull && compReq) |=> rstFull);

  // R8: a lone compatibility request into an idle block is partial
  p_comp_partial_r8: assert property (@(posedge clk) disable iff (porRst)
    (compReq && !sysReq && !rstActive) |=> (rstActive && !rstFull));
endmodule

// File: rtl/clkrst_datapath.sv
`timescale 1ns/1ps
module clkrst_datapath
  import clkrst_pkg::*;
#(
  parameter int FAST_DIV   = 2,
  parameter int RST_CYCLES = 56
) (
  input  logic         clk,
  input  logic         porRst,
  input  ctrl_strobe_t strobes,
  input  logic         strobeIn,
  output logic         cntDone,
  output logic         cpuEn,
  output logic [2:0]   speedStatus,
  output logic         cpuRstN,
  output logic         periphRstN,
  output logic         basePortRstN,
  output logic         extPortRstN,
  output logic         printerStrobe,
  output logic         forceLocalOsc
);
  localparam int MID_DIV  = 2 * FAST_DIV;
  localparam int SLOW_DIV = 4 * FAST_DIV;
  localparam int DW       = (SLOW_DIV > 1) ? $clog2(SLOW_DIV) : 1;
  localparam int CW       = $clog2(RST_CYCLES + 1);

  logic [DW-1:0] divCnt;
  logic [DW-1:0] lastIdx;
  speed_e        activeSpeed;
  logic [CW-1:0] rstCnt;
  logic          anyRst;
  logic          extRst;

  // divider: period restarts at every pulse using the rate then in effect
  always_comb begin
    case (activeSpeed)
      SPD_FAST: lastIdx = DW'(FAST_DIV - 1);
      SPD_MID:  lastIdx = DW'(MID_DIV - 1);
      default:  lastIdx = DW'(SLOW_DIV - 1);
    endcase
  end

  assign cpuEn = (divCnt == lastIdx);

  always_ff @(posedge clk or posedge porRst) begin
    if (porRst) begin
      divCnt      <= '0;
      activeSpeed <= SPD_SLOW;
    end else if (cpuEn) begin
      divCnt      <= '0;
      activeSpeed <= strobes.reqSpeed;
    end else begin
      divCnt      <= divCnt + 1'b1;
    end
  end

  // reset length counter
  always_ff @(posedge clk or posedge porRst) begin
    if (porRst)                                  rstCnt <= '0;
    else if (strobes.rstLoad)                    rstCnt <= CW'(RST_CYCLES - 1);
    else if (strobes.rstActive && rstCnt != '0)  rstCnt <= rstCnt - 1'b1;
  end

  assign cntDone = (rstCnt == '0);

  assign anyRst        = porRst | strobes.rstActive;
  assign extRst        = porRst | (strobes.rstActive & strobes.rstFull);
  assign cpuRstN       = ~anyRst;
  assign periphRstN    = ~anyRst;
  assign basePortRstN  = ~anyRst;
  assign extPortRstN   = ~extRst;
  assign printerStrobe = anyRst | strobeIn;
  assign forceLocalOsc = porRst;
  assign speedStatus   = activeSpeed;

  // R6: status always one-hot
  p_status_onehot_r6: assert property (@(posedge clk) disable iff (porRst)
    $countones(speedStatus) == 1);

  // R5: the rate in effect only moves on a pulse edge
  p_rate_hold_r5: assert property (@(posedge clk) disable iff (porRst)
    !cpuEn |=> $stable(speedStatus));

  // R2: enable pulse is one cycle wide
  p_pulse_single_r2: assert property (@(posedge clk) disable iff (porRst)
    (cpuEn && FAST_DIV > 1) |=> !cpuEn);

  // R9: every request reloads the full length
  p_reload_r9: assert property (@(posedge clk) disable iff (porRst)
    strobes.rstLoad |=> (rstCnt == CW'(RST_CYCLES - 1)));

  // R8: extended ports are never in reset without the CPU
  p_ext_subset_r8: assert property (@(posedge clk) disable iff (porRst)
    !extPortRstN |-> !cpuRstN);
endmodule

// File: rtl/cpu_clock_reset.sv
`timescale 1ns/1ps
module cpu_clock_reset #(
  parameter int FAST_DIV   = 2,
  parameter int RST_CYCLES = 56
) (
  input  logic       clk,
  input  logic       porN,
  input  logic       sysReq,
  input  logic       compReq,
  input  logic [1:0] hwSel,
  input  logic [1:0] forceCode,
  input  logic       strobeIn,
  output logic       cpuEn,
  output logic [2:0] speedStatus,
  output logic       cpuRstN,
  output logic       periphRstN,
  output logic       basePortRstN,
  output logic       extPortRstN,
  output logic       printerStrobe,
  output logic       forceLocalOsc
);
  import clkrst_pkg::*;

  logic         porRst;
  logic         cntDone;
  ctrl_strobe_t strobes;

  clkrst_porsync #(.STAGES(2)) u_porsync (
    .clk    (clk),
    .porN   (porN),
    .porRst (porRst)
  );

  clkrst_ctrl u_ctrl (
    .clk       (clk),
    .porRst    (porRst),
    .sysReq    (sysReq),
    .compReq   (compReq),
    .hwSel     (hwSel),
    .forceCode (forceCode),
    .cntDone   (cntDone),
    .strobes   (strobes)
  );

  clkrst_datapath #(.FAST_DIV(FAST_DIV), .RST_CYCLES(RST_CYCLES)) u_dp (
    .clk           (clk),
    .porRst        (porRst),
    .strobes       (strobes),
    .strobeIn      (strobeIn),
    .cntDone       (cntDone),
    .cpuEn         (cpuEn),
    .speedStatus   (speedStatus),
    .cpuRstN       (cpuRstN),
    .periphRstN    (periphRstN),
    .basePortRstN  (basePortRstN),
    .extPortRstN   (extPortRstN),
    .printerStrobe (printerStrobe),
    .forceLocalOsc (forceLocalOsc)
  );
endmodule

// File: tb/cpu_clock_reset_tb.sv
`timescale 1ns/1ps
module cpu_clock_reset_tb;
  localparam int CLK_PERIOD = 36;
  localparam int FAST      = 2;
  localparam int RST_LEN   = 56;

  logic clk = 1'b0;
  logic porN, sysReq, compReq, strobeIn;
  logic [1:0] hwSel, forceCode;
  logic cpuEn, cpuRstN, periphRstN, basePortRstN, extPortRstN;
  logic printerStrobe, forceLocalOsc;
  logic [2:0] speedStatus;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  cpu_clock_reset #(.FAST_DIV(FAST), .RST_CYCLES(RST_LEN)) u_dut (
    .clk(clk), .porN(porN), .sysReq(sysReq), .compReq(compReq),
    .hwSel(hwSel), .forceCode(forceCode), .strobeIn(strobeIn),
    .cpuEn(cpuEn), .speedStatus(speedStatus), .cpuRstN(cpuRstN),
    .periphRstN(periphRstN), .basePortRstN(basePortRstN),
    .extPortRstN(extPortRstN), .printerStrobe(printerStrobe),
    .forceLocalOsc(forceLocalOsc)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // falling edges until the next enable pulse
  task automatic waitEn(output int gap);
    gap = 0;
    for (int i = 0; i < 100; i++) begin
      @(negedge clk);
      gap++;
      if (cpuEn) break;
    end
  endtask

  task automatic measureRate(input int expGap, input logic [2:0] expStat, input string req);
    int g;
    waitEn(g); waitEn(g); waitEn(g);
    check(g == expGap, req, g, expGap);
    waitEn(g);
    check(g == expGap, req, g, expGap);
    @(negedge clk);
    check(speedStatus == expStat, {req, " status"}, speedStatus, expStat);
  endtask

  task automatic testPowerOn();
    check(cpuRstN == 0 && periphRstN == 0 && basePortRstN == 0 && extPortRstN == 0,
          "R1 resets low", {cpuRstN, periphRstN, basePortRstN, extPortRstN}, 0);
    check(forceLocalOsc == 1, "R1 osc", forceLocalOsc, 1);
    check(speedStatus == 3'b001, "R1 status", speedStatus, 1);
    check(printerStrobe == 1, "R11 strobe in POR", printerStrobe, 1);
    porN = 1'b1;
    @(negedge clk);
    check(cpuRstN == 0, "R1 held after 1 edge", cpuRstN, 0);
    @(negedge clk);
    check(cpuRstN == 1 && extPortRstN == 1 && forceLocalOsc == 0,
          "R1 released after 2 edges", {cpuRstN, extPortRstN, forceLocalOsc}, 3'b110);
    check(printerStrobe == 0, "R11 strobe follows input", printerStrobe, 0);
  endtask

  task automatic testHardware();
    forceCode = 2'b00;
    hwSel = 2'b00; measureRate(4*FAST, 3'b001, "R4 hw 00");
    hwSel = 2'b10; measureRate(2*FAST, 3'b010, "R4 hw 10");
    hwSel = 2'b11; measureRate(FAST,   3'b100, "R4 hw 11");
    hwSel = 2'b01; measureRate(4*FAST, 3'b001, "R4 hw 01");
  endtask

  task automatic testForce();
    hwSel = 2'b11;
    forceCode = 2'b01; measureRate(4*FAST, 3'b001, "R3 force 01 R2");
    hwSel = 2'b00;
    forceCode = 2'b10; measureRate(2*FAST, 3'b010, "R3 force 10 R2");
    forceCode = 2'b11; measureRate(FAST,   3'b100, "R3 force 11 R2");
  endtask

  task automatic switchRate(input logic [1:0] from, input logic [1:0] to,
                            input int oldGap, input int newGap,
                            input logic [2:0] oldStat, input logic [2:0] newStat);
    int g;
    forceCode = from;
    waitEn(g); waitEn(g); waitEn(g);
    @(negedge clk);
    forceCode = to;
    waitEn(g);
    check(g + 1 == oldGap, "R5 old interval kept", g + 1, oldGap);
    check(speedStatus == oldStat, "R6 status on pulse cycle", speedStatus, oldStat);
    waitEn(g);
    check(g == newGap, "R5 new interval", g, newGap);
    check(speedStatus == newStat, "R6 status updated", speedStatus, newStat);
  endtask

  // sample reset outputs each falling edge; optional second request
  task automatic runReset(input bit firstSys, input bit firstComp,
                          input int secondAt, input bit secondSys,
                          output int cpuLow, output int extLow,
                          output int enCnt, output int stbHigh, output int mism);
    cpuLow = 0; extLow = 0; enCnt = 0; stbHigh = 0; mism = 0;
    @(negedge clk);
    sysReq = firstSys; compReq = firstComp;
    for (int i = 1; i < 400; i++) begin
      @(negedge clk);
      if (i == 1) begin sysReq = 1'b0; compReq = 1'b0; end
      if (cpuRstN) break;
      cpuLow++;
      if (!extPortRstN) extLow++;
      if (cpuEn) enCnt++;
      if (printerStrobe) stbHigh++;
      if (periphRstN != cpuRstN || basePortRstN != cpuRstN) mism++;
      if (secondAt != 0 && i == secondAt) begin
        if (secondSys) sysReq = 1'b1; else compReq = 1'b1;
      end
      if (secondAt != 0 && i == secondAt + 1) begin sysReq = 1'b0; compReq = 1'b0; end
    end
  endtask

  task automatic testSystem();
    int c, e, n, s, m;
    forceCode = 2'b11;
    repeat (6) @(negedge clk);
    runReset(1, 0, 0, 0, c, e, n, s, m);
    check(c == RST_LEN, "R7 cpu reset length", c, RST_LEN);
    check(e == RST_LEN, "R7 ext reset length", e, RST_LEN);
    check(m == 0, "R7 periph/base track cpu", m, 0);
    check(n == RST_LEN / FAST, "R10 enable continues", n, RST_LEN / FAST);
    check(s == RST_LEN, "R11 strobe high in reset", s, RST_LEN);
    check(printerStrobe == 0, "R11 strobe after reset", printerStrobe, 0);
  endtask

  task automatic testCompat();
    int c, e, n, s, m;
    runReset(0, 1, 0, 0, c, e, n, s, m);
    check(c == RST_LEN, "R8 cpu reset length", c, RST_LEN);
    check(e == 0, "R8 ext ports untouched", e, 0);
    check(m == 0, "R8 periph/base track cpu", m, 0);
  endtask

  task automatic testRestart();
    int c, e, n, s, m;
    runReset(0, 1, 20, 1, c, e, n, s, m);
    check(c == 20 + RST_LEN, "R9 restart length", c, 20 + RST_LEN);
    check(e == RST_LEN, "R9 ext from system edge", e, RST_LEN);
    runReset(1, 0, 30, 0, c, e, n, s, m);
    check(c == 30 + RST_LEN, "R9 restart by compat", c, 30 + RST_LEN);
    check(e == 30 + RST_LEN, "R9 full kind held", e, 30 + RST_LEN);
  endtask

  task automatic testBoth();
    int c, e, n, s, m;
    runReset(1, 1, 0, 0, c, e, n, s, m);
    check(c == RST_LEN && e == RST_LEN, "R12 both requests act as system", e, RST_LEN);
  endtask

  task automatic testPorMid();
    forceCode = 2'b11;
    strobeIn = 1'b0;
    repeat (10) @(negedge clk);
    #(CLK_PERIOD/4);
    porN = 1'b0;
    #1;
    check(cpuRstN == 0 && extPortRstN == 0, "R1 async assert", {cpuRstN, extPortRstN}, 0);
    check(speedStatus == 3'b001, "R1 async slow", speedStatus, 1);
    check(forceLocalOsc == 1 && printerStrobe == 1, "R1 R11 osc/strobe",
          {forceLocalOsc, printerStrobe}, 3);
    @(negedge clk);
    porN = 1'b1;
    repeat (3) @(negedge clk);
    measureRate(FAST, 3'b100, "R3 rate after POR");
  endtask

  initial begin
    porN = 1'b0; sysReq = 1'b0; compReq = 1'b0;
    hwSel = 2'b00; forceCode = 2'b00; strobeIn = 1'b0;
    repeat (3) @(negedge clk);
    testPowerOn();
    testHardware();
    testForce();
    switchRate(2'b01, 2'b11, 4*FAST, FAST, 3'b001, 3'b100);
    switchRate(2'b11, 2'b01, FAST, 4*FAST, 3'b100, 3'b001);
    switchRate(2'b10, 2'b01, 2*FAST, 4*FAST, 3'b010, 3'b001);
    testSystem();
    strobeIn = 1'b1;
    @(negedge clk);
    check(printerStrobe == 1, "R11 strobe follows input high", printerStrobe, 1);
    strobeIn = 1'b0;
    testCompat();
    testRestart();
    testBoth();
    testPorMid();
    if (!done) begin
      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++; errors++;
      $display("FAIL watchdog: actual 1 expected 0");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule